// File: doc/BRIEF.md
# Frame Receive FIFO Controller

This block sits between a bit-level frame deframer and a host. It accepts the bytes of HDLC-style frames, together with start and end markers and a per-frame status byte. It stores them in a 64-byte buffer that is split into two equal banks and used in ping-pong fashion. The bytes reach the host in blocks whose size is set by a 2-bit threshold code. A block is handed to the host when it holds a full block of an unfinished frame, or when the frame ends. The host then reads the block through a simple byte read port and gives the bank back with an explicit release pulse. Until that pulse the bank stays occupied.

With every handed-over block the host also sees a snapshot of the running frame byte count. From that count it learns the total frame length so far. The low bits of the count give the number of bytes that sit in the current block. Four sticky flags report events: a threshold block is ready, a frame has ended, a frame has started, and a byte was lost for lack of space. In address mode a frame is accepted only when its first byte matches a configured address. Frames with any other first byte are discarded whole.

Top module: `frame_rx_fifo`

## Requirements
- R1: After reset, all four flags are 0, `rd_avail` is 0, `rd_count` is 0 and `rd_frame_end` is 0.
- R2: Threshold code `cfg_thr` selects the block size: 0 gives 32 bytes, 1 gives 16, 2 gives 4 and 3 gives 2. After that many data bytes of an unfinished frame are stored, the block is handed over on the next clock edge. At that point `rd_avail`=1, `rd_frame_end`=0 and `irq_thr` is set.
- R3: An end strobe (`in_eof` with `in_valid` low) writes `in_stat` into the buffer and closes the current block on the next edge. The block is handed over with `rd_frame_end`=1 and `irq_mend` set. This happens for a short frame and for the final part of a frame that spans several blocks.
- R4: `rd_count` is the number of bytes of the frame stored up to and including the head block, counting the status byte. Its low 5, 4, 2 or 1 bits (for codes 0 to 3) give the bytes in the block, where 0 means a full block.
- R5: Reading a block through `rd_data`/`rd_en` returns the frame bytes in arrival order. The status byte is the last byte of the frame's final block.
- R6: A handed-over block stays at the head with unchanged `rd_count` until `rel_cmd` is pulsed. The pulse frees the bank and moves the head to the next block. A `rel_cmd` pulse while `rd_avail`=0 has no effect.
- R7: When address mode is off, a byte with `in_sof`=1 starts a frame and sets `irq_fstart`.
- R8: With `cfg_addr_mode`=1, a start byte equal to `cfg_addr` sets `irq_fstart` and is stored as the first byte. Any other start byte causes the whole frame, including its status byte, to be dropped with no flag set.
- R9: Flags stay set until `irq_clr` is pulsed. A flag that is set in the same cycle as the clear stays set.
- R10: A byte that arrives while both banks are occupied sets `st_ovf` and is dropped. The rest of that frame, including its end, is dropped until the next start byte.
- R11: While the host holds one block, the next block of the same frame fills the other bank, and the blocks are presented in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Data byte strobe from the deframer |
| in_sof | input | 1 | Marks the data byte as the first of a frame |
| in_data | input | 8 | Received data byte |
| in_eof | input | 1 | Frame end strobe, given alone in its cycle |
| in_stat | input | 8 | Frame status byte, stored on the end strobe |
| cfg_thr | input | 2 | Block size code |
| cfg_addr_mode | input | 1 | Enable address filtering on the start byte |
| cfg_addr | input | 8 | Address compared with the start byte |
| rd_en | input | 1 | Advance the read pointer of the head block |
| rd_data | output | 8 | Byte at the read pointer of the head block |
| rd_avail | output | 1 | A block is ready at the head |
| rd_count | output | 16 | Frame byte count snapshot of the head block |
| rd_frame_end | output | 1 | Head block ends its frame |
| rel_cmd | input | 1 | Release the head block |
| irq_clr | input | 1 | Clear all flags |
| irq_thr | output | 1 | Sticky: threshold block ready |
| irq_mend | output | 1 | Sticky: frame end stored |
| irq_fstart | output | 1 | Sticky: valid frame start |
| st_ovf | output | 1 | Sticky: byte lost for lack of space |

## Verification
Each input byte, end strobe, read step, release or clear is taken on one rising edge. Its result appears after that same edge: the stored byte, the handover, the flags, the count snapshot and the new head data. No result waits for a further edge. The bench drives every input on the falling edge and compares outputs on the next falling edge, which is one full edge after the capture. For a read it checks `rd_data` before pulsing `rd_en`. Two cycles of synchronizer latency after reset release are allowed before any stimulus.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [1:0] {
    THR_FULL      = 2'd0,
    THR_HALF      = 2'd1,
    THR_EIGHTH    = 2'd2,
    THR_SIXTEENTH = 2'd3
  } thr_code_e;

  typedef struct packed {
    logic valid;
    logic bank;
    logic last;
  } handover_t;

  function automatic int unsigned blk_bytes(input logic [1:0] code,
                                            input int unsigned bank_depth);
    case (thr_code_e'(code))
      THR_FULL:   return bank_depth;
      THR_HALF:   return bank_depth / 2;
      THR_EIGHTH: return bank_depth / 8;
      default:    return bank_depth / 16;
    endcase
  endfunction

endpackage

// File: rtl/frx_store.sv
module frx_store #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/frx_wr_ctrl.sv
module frx_wr_ctrl
  import frx_pkg::*;
#(
  parameter int BANK_DEPTH = 32,
  parameter int CNT_W      = 16,
  localparam int PTR_W     = $clog2(BANK_DEPTH),
  localparam int FILL_W    = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic             in_eof,
  input  logic [7:0]       in_stat,
  input  logic [1:0]       cfg_thr,
  input  logic             cfg_addr_mode,
  input  logic [7:0]       cfg_addr,
  input  logic [1:0]       bank_busy,
  output logic             mem_we,
  output logic [PTR_W:0]   mem_waddr,
  output logic [7:0]       mem_wdata,
  output handover_t        ho,
  output logic [CNT_W-1:0] ho_cnt,
  output logic             fs_pulse,
  output logic             ovf_pulse
);

  logic              open_q, open_d;
  logic              wbank_q, wbank_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic              start, end_ev, accept, open_eff, want, space, ev;
  logic [FILL_W-1:0] blk, fill_inc;
  logic [CNT_W-1:0]  cnt_base, cnt_inc;
  logic              blk_done;

  always_comb begin
    blk      = FILL_W'(blk_bytes(cfg_thr, BANK_DEPTH));
    start    = in_valid & in_sof;
    end_ev   = in_eof & ~in_valid;
    accept   = ~cfg_addr_mode | (in_data == cfg_addr);
    open_eff = start ? accept : open_q;
    space    = ~bank_busy[wbank_q];
    want     = open_eff & (in_valid | end_ev);
    ev       = in_valid | end_ev;

    cnt_base = start ? '0 : cnt_q;
    cnt_inc  = cnt_base + CNT_W'(1);
    fill_inc = fill_q + FILL_W'(1);
    blk_done = end_ev | (fill_inc >= blk);

    mem_we    = want & space;
    mem_waddr = {wbank_q, fill_q[PTR_W-1:0]};
    mem_wdata = in_valid ? in_data : in_stat;

    ho.valid  = mem_we & blk_done;
    ho.bank   = wbank_q;
    ho.last   = end_ev;
    ho_cnt    = cnt_inc;

    fs_pulse  = start & accept;
    ovf_pulse = want & ~space;
  end

  // next state
  always_comb begin
    open_d  = open_q;
    wbank_d = wbank_q;
    fill_d  = fill_q;
    cnt_d   = cnt_base;
    if (start) begin
      open_d = accept;
    end
    if (ovf_pulse || end_ev) begin
      open_d = 1'b0;
    end
    if (mem_we) begin
      cnt_d = cnt_inc;
      if (blk_done) begin
        fill_d  = '0;
        wbank_d = ~wbank_q;
      end else begin
        fill_d  = fill_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      wbank_q <= 1'b0;
      fill_q  <= '0;
      cnt_q   <= '0;
    end else if (ev) begin
      open_q  <= open_d;
      wbank_q <= wbank_d;
      fill_q  <= fill_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_DROP_REST: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !open_q); // R10

  AST_FILL_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (fill_q < FILL_W'(BANK_DEPTH))); // R2

endmodule

// File: rtl/frx_rd_ctrl.sv
module frx_rd_ctrl
  import frx_pkg::*;
#(
  parameter int BANK_DEPTH = 32,
  parameter int CNT_W      = 16,
  localparam int NBANK     = 2,
  localparam int PTR_W     = $clog2(BANK_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  handover_t        ho,
  input  logic [CNT_W-1:0] ho_cnt,
  input  logic             rd_en,
  input  logic             rel_cmd,
  output logic [NBANK-1:0] bank_busy,
  output logic             rd_avail,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_frame_end,
  output logic [PTR_W:0]   mem_raddr
);

  logic [NBANK-1:0] rdy_q, rdy_d;
  logic [NBANK-1:0] last_q, last_d;
  logic [CNT_W-1:0] snap_q [NBANK];
  logic [CNT_W-1:0] snap_d [NBANK];
  logic             rbank_q, rbank_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic             head_rdy, rel_ok, step_ok;

  assign head_rdy = rdy_q[rbank_q];
  assign rel_ok   = rel_cmd & head_rdy;
  assign step_ok  = rd_en & head_rdy;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic set_b, clr_b;
    assign set_b     = ho.valid & (ho.bank == 1'(g));
    assign clr_b     = rel_ok & (rbank_q == 1'(g));
    assign rdy_d[g]  = set_b | (rdy_q[g] & ~clr_b);
    assign last_d[g] = set_b ? ho.last : last_q[g];
    assign snap_d[g] = set_b ? ho_cnt : snap_q[g];
  end

  always_comb begin
    rbank_d = rbank_q;
    rptr_d  = rptr_q;
    if (rel_ok) begin
      rbank_d = ~rbank_q;
      rptr_d  = '0;
    end else if (step_ok) begin
      rptr_d  = rptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= '0;
      last_q  <= '0;
      rbank_q <= 1'b0;
      rptr_q  <= '0;
      for (int i = 0; i < NBANK; i++) snap_q[i] <= '0;
    end else begin
      rdy_q  <= rdy_d;
      last_q <= last_d;
      if (ho.valid) begin
        for (int i = 0; i < NBANK; i++) snap_q[i] <= snap_d[i];
      end
      if (rel_ok || step_ok) begin
        rbank_q <= rbank_d;
        rptr_q  <= rptr_d;
      end
    end
  end

  assign bank_busy    = rdy_q;
  assign rd_avail     = head_rdy;
  assign rd_count     = head_rdy ? snap_q[rbank_q] : '0;
  assign rd_frame_end = head_rdy & last_q[rbank_q];
  assign mem_raddr    = {rbank_q, rptr_q};

  AST_HOLD_TILL_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_avail && !rel_cmd) |=> (rd_avail && $stable(rd_count))); // R6

  AST_REL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_avail && rel_cmd) |=> $stable(mem_raddr)); // R6

  AST_HO_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    ho.valid |-> !bank_busy[ho.bank]); // R11

endmodule

// File: rtl/frx_flags.sv
module frx_flags #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic             clr,
  output logic [NFLAG-1:0] flags
);

  logic [NFLAG-1:0] flag_q, flag_d;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign flag_d[g] = set[g] | (flag_q[g] & ~clr);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr) |=> flag_q[g]); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> flag_q[g]); // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if ((|set) || clr) begin
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

endmodule

// File: rtl/frame_rx_fifo.sv
module frame_rx_fifo
  import frx_pkg::*;
#(
  parameter int BANK_DEPTH = 32,
  parameter int CNT_W      = 16,
  localparam int DEPTH     = 2 * BANK_DEPTH,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [7:0]       in_data,
  input  logic             in_eof,
  input  logic [7:0]       in_stat,
  input  logic [1:0]       cfg_thr,
  input  logic             cfg_addr_mode,
  input  logic [7:0]       cfg_addr,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_avail,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_frame_end,
  input  logic             rel_cmd,
  input  logic             irq_clr,
  output logic             irq_thr,
  output logic             irq_mend,
  output logic             irq_fstart,
  output logic             st_ovf
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata;
  handover_t         ho;
  logic [CNT_W-1:0]  ho_cnt;
  logic              fs_pulse, ovf_pulse;
  logic [1:0]        bank_busy;
  logic [3:0]        flag_set, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  frx_wr_ctrl #(.BANK_DEPTH(BANK_DEPTH), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .in_eof(in_eof), .in_stat(in_stat),
    .cfg_thr(cfg_thr), .cfg_addr_mode(cfg_addr_mode), .cfg_addr(cfg_addr),
    .bank_busy(bank_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ho(ho), .ho_cnt(ho_cnt), .fs_pulse(fs_pulse), .ovf_pulse(ovf_pulse)
  );

  frx_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(rd_data)
  );

  frx_rd_ctrl #(.BANK_DEPTH(BANK_DEPTH), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_sync_n),
    .ho(ho), .ho_cnt(ho_cnt), .rd_en(rd_en), .rel_cmd(rel_cmd),
    .bank_busy(bank_busy), .rd_avail(rd_avail), .rd_count(rd_count),
    .rd_frame_end(rd_frame_end), .mem_raddr(mem_raddr)
  );

  assign flag_set = {ovf_pulse, fs_pulse, ho.valid & ho.last, ho.valid & ~ho.last};

  frx_flags #(.NFLAG(4)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set(flag_set), .clr(irq_clr), .flags(flags)
  );

  assign irq_thr    = flags[0];
  assign irq_mend   = flags[1];
  assign irq_fstart = flags[2];
  assign st_ovf     = flags[3];

  AST_FSTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_fstart) |-> $past(in_valid && in_sof)); // R7

  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(st_ovf) |-> $past(rd_avail)); // R10

  AST_MEND_FLAGS_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_mend) |-> $past(in_eof)); // R3

endmodule

// File: tb/tb_frame_rx_fifo.sv
module tb_frame_rx_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, cfg_addr_mode, rd_en, rel_cmd, irq_clr;
  logic [7:0]  in_data, in_stat, cfg_addr, rd_data;
  logic [1:0]  cfg_thr;
  logic        rd_avail, rd_frame_end, irq_thr, irq_mend, irq_fstart, st_ovf;
  logic [15:0] rd_count;
  int          checks = 0;
  int          fails  = 0;

  always #2 clk = ~clk;

  frame_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .in_eof(in_eof), .in_stat(in_stat), .cfg_thr(cfg_thr),
    .cfg_addr_mode(cfg_addr_mode), .cfg_addr(cfg_addr), .rd_en(rd_en),
    .rd_data(rd_data), .rd_avail(rd_avail), .rd_count(rd_count),
    .rd_frame_end(rd_frame_end), .rel_cmd(rel_cmd), .irq_clr(irq_clr),
    .irq_thr(irq_thr), .irq_mend(irq_mend), .irq_fstart(irq_fstart),
    .st_ovf(st_ovf)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic sof);
    in_valid = 1'b1; in_sof = sof; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic put_end(input logic [7:0] s);
    in_eof = 1'b1; in_stat = s;
    @(negedge clk);
    in_eof = 1'b0;
  endtask

  task automatic pulse_rel();
    rel_cmd = 1'b1; @(negedge clk); rel_cmd = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic read_one(input string req, input logic [7:0] exp);
    chk(req, "rd_data", {24'd0, rd_data}, {24'd0, exp});
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int blk_of(input int code);
    return (code == 0) ? 32 : (code == 1) ? 16 : (code == 2) ? 4 : 2;
  endfunction

  task automatic t_reset();
    chk("R1", "irq_thr", {31'd0, irq_thr}, 0);
    chk("R1", "irq_mend", {31'd0, irq_mend}, 0);
    chk("R1", "irq_fstart", {31'd0, irq_fstart}, 0);
    chk("R1", "st_ovf", {31'd0, st_ovf}, 0);
    chk("R1", "rd_avail", {31'd0, rd_avail}, 0);
    chk("R1", "rd_count", {16'd0, rd_count}, 0);
    chk("R1", "rd_frame_end", {31'd0, rd_frame_end}, 0);
  endtask

  task automatic t_short_frame();
    cfg_thr = 2'd0;
    put(8'h10, 1'b1);
    chk("R7", "irq_fstart", {31'd0, irq_fstart}, 1);
    for (int i = 1; i < 5; i++) put(8'h10 + 8'(i), 1'b0);
    chk("R6", "rd_avail before end", {31'd0, rd_avail}, 0);
    put_end(8'hA5);
    chk("R3", "irq_mend", {31'd0, irq_mend}, 1);
    chk("R3", "irq_thr", {31'd0, irq_thr}, 0);
    chk("R3", "rd_frame_end", {31'd0, rd_frame_end}, 1);
    chk("R4", "rd_count", {16'd0, rd_count}, 6);
    for (int i = 0; i < 5; i++) read_one("R5", 8'h10 + 8'(i));
    read_one("R5", 8'hA5);
    chk("R6", "rd_avail held", {31'd0, rd_avail}, 1);
    pulse_rel();
    chk("R6", "rd_avail after release", {31'd0, rd_avail}, 0);
    pulse_rel();
    chk("R6", "spare release", {31'd0, rd_avail}, 0);
    pulse_clr();
    chk("R9", "flags cleared", {28'd0, st_ovf, irq_fstart, irq_mend, irq_thr}, 0);
  endtask

  task automatic t_thresholds();
    for (int c = 0; c < 4; c++) begin
      int b;
      b = blk_of(c);
      cfg_thr = 2'(c);
      for (int i = 0; i < b; i++) put(8'(8'h40 + i), i == 0);
      chk("R2", "rd_avail full block", {31'd0, rd_avail}, 1);
      chk("R2", "irq_thr", {31'd0, irq_thr}, 1);
      chk("R2", "rd_frame_end", {31'd0, rd_frame_end}, 0);
      chk("R4", "rd_count full", {16'd0, rd_count}, 32'(b));
      chk("R4", "low bits full", {16'd0, rd_count} & 32'(b - 1), 0);
      put_end(8'hC0 + 8'(c));
      chk("R3", "irq_mend", {31'd0, irq_mend}, 1);
      read_one("R5", 8'h40);
      pulse_rel();
      chk("R11", "tail block", {31'd0, rd_avail}, 1);
      chk("R4", "tail count", {16'd0, rd_count}, 32'(b + 1));
      chk("R4", "tail low bits", {16'd0, rd_count} & 32'(b - 1), 1);
      chk("R3", "tail frame_end", {31'd0, rd_frame_end}, 1);
      read_one("R5", 8'hC0 + 8'(c));
      pulse_rel();
      pulse_clr();
    end
  endtask

  task automatic t_long_frame();
    cfg_thr = 2'd2;
    for (int i = 0; i < 8; i++) put(8'h80 + 8'(i), i == 0);
    chk("R11", "first block count", {16'd0, rd_count}, 4);
    for (int i = 0; i < 4; i++) read_one("R11", 8'h80 + 8'(i));
    pulse_rel();
    chk("R11", "second block count", {16'd0, rd_count}, 8);
    for (int i = 4; i < 8; i++) read_one("R11", 8'h80 + 8'(i));
    pulse_rel();
    put(8'h88, 1'b0);
    put(8'h89, 1'b0);
    put_end(8'h5A);
    chk("R3", "last part frame_end", {31'd0, rd_frame_end}, 1);
    chk("R4", "total count", {16'd0, rd_count}, 11);
    chk("R4", "bytes in last block", {16'd0, rd_count} & 32'd3, 3);
    read_one("R5", 8'h88);
    read_one("R5", 8'h89);
    read_one("R5", 8'h5A);
    pulse_rel();
    pulse_clr();
  endtask

  task automatic t_overflow();
    cfg_thr = 2'd3;
    for (int i = 0; i < 4; i++) put(8'h50 + 8'(i), i == 0);
    chk("R10", "no ovf yet", {31'd0, st_ovf}, 0);
    put(8'h54, 1'b0);
    chk("R10", "st_ovf", {31'd0, st_ovf}, 1);
    put(8'h55, 1'b0);
    pulse_clr();
    put_end(8'hEE);
    chk("R10", "end dropped", {31'd0, irq_mend}, 0);
    chk("R10", "no second ovf", {31'd0, st_ovf}, 0);
    read_one("R10", 8'h50);
    read_one("R10", 8'h51);
    pulse_rel();
    chk("R10", "second block count", {16'd0, rd_count}, 4);
    read_one("R10", 8'h52);
    read_one("R10", 8'h53);
    pulse_rel();
    chk("R10", "nothing kept", {31'd0, rd_avail}, 0);
    put(8'h60, 1'b1);
    put_end(8'h61);
    chk("R10", "recovery count", {16'd0, rd_count}, 2);
    read_one("R10", 8'h60);
    read_one("R10", 8'h61);
    pulse_rel();
    pulse_clr();
  endtask

  task automatic t_address();
    cfg_thr = 2'd0; cfg_addr_mode = 1'b1; cfg_addr = 8'h3C;
    put(8'h11, 1'b1);
    put(8'h12, 1'b0);
    put_end(8'h99);
    chk("R8", "mismatch avail", {31'd0, rd_avail}, 0);
    chk("R8", "mismatch fstart", {31'd0, irq_fstart}, 0);
    chk("R8", "mismatch mend", {31'd0, irq_mend}, 0);
    put(8'h3C, 1'b1);
    chk("R8", "match fstart", {31'd0, irq_fstart}, 1);
    put(8'h3D, 1'b0);
    put_end(8'h77);
    chk("R8", "match count", {16'd0, rd_count}, 3);
    read_one("R8", 8'h3C);
    read_one("R8", 8'h3D);
    read_one("R8", 8'h77);
    pulse_rel();
    pulse_clr();
    cfg_addr_mode = 1'b0;
  endtask

  task automatic t_set_wins();
    irq_clr = 1'b1;
    put(8'h21, 1'b1);
    irq_clr = 1'b0;
    chk("R9", "set beats clear", {31'd0, irq_fstart}, 1);
    repeat (3) @(negedge clk);
    chk("R9", "sticky", {31'd0, irq_fstart}, 1);
    put_end(8'h22);
    pulse_clr();
    chk("R9", "cleared", {31'd0, irq_fstart | irq_mend}, 0);
    read_one("R9", 8'h21);
    read_one("R9", 8'h22);
    pulse_rel();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0; in_stat = '0;
    cfg_thr = 2'd0; cfg_addr_mode = 1'b0; cfg_addr = '0;
    rd_en = 1'b0; rel_cmd = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_short_frame();
    t_thresholds();
    t_long_frame();
    t_overflow();
    t_address();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule